// File: doc/BRIEF.md
# Paging Address Matcher and Call Terminator

This block sits after the error corrector in a paging decoder. The block takes one 32-bit codeword per valid cycle, together with a flag that says the corrector could not repair it, a flag that marks the batch synchronisation slot, and the index of the frame the codeword arrived in. Bit 1 is the codeword MSB, carried on `cw_i[31]`. An address codeword has an MSB of 0. The block compares each address codeword with four programmed user addresses. When one of them matches, the block opens a call.

While a call is open, the frame structure is suspended. Every following codeword is taken in order, whatever frame index comes with it. The payload of each message codeword goes straight out. The call closes on an idle codeword, on an address codeword, or under a selectable policy for uncorrectable codewords. When an address codeword closes a call, the block evaluates it again in the same cycle as a possible new call. The close pulse carries the identity and function bits of the call that ended, and it is the request to start alerting. No alert request comes out earlier.

All outputs are registered. They respond one clock after the codeword is presented.

Top module: `pgr_call_ctrl`

## Requirements
- R1: A corrected codeword that is not idle and has `cw_i[31]`=0 starts a call when `cw_i[30:13]` equals a stored address and `frame_i` equals that address's frame. Addresses 0 and 1 use `frame_lo_i`; addresses 2 and 3 use `frame_hi_i`. One cycle later, `call_start_o` pulses, `call_idx_o` gives the matching address (the lowest index wins), and `call_func_o` = `cw_i[12:11]`.
- R2: No call starts from an address codeword that matches no address, arrives in another frame, or is flagged uncorrectable.
- R3: Inside a call, each corrected codeword with `cw_i[31]`=1 gives `msg_valid_o` one cycle later, with `msg_data_o` = `cw_i[30:11]`. The frame index is ignored. Outside a call, message codewords produce nothing.
- R4: A corrected codeword equal to `IDLE_CW` (default 32'h7A89C197) ends an open call. One cycle later, `call_end_o` pulses, and `end_idx_o` and `end_func_o` hold the ended call's identity and function bits. `call_end_o` is the only alert request and never fires outside a call.
- R5: A corrected address codeword inside a call ends the call. If that codeword also matches per R1, a new call starts in the same cycle, so `call_end_o` and `call_start_o` pulse together.
- R6: With `err_pol_i`=2'b10, any single uncorrectable codeword inside a call ends it.
- R7: With `err_pol_i`=2'b11, only two consecutive uncorrectable codewords end a call. A lone uncorrectable codeword is dropped without output. A corrected codeword in between restarts the count.
- R8: With `err_pol_i[1]`=0, a call ends on two consecutive uncorrectable codewords, or when the first codeword after the address is uncorrectable.
- R9: A codeword presented with `sync_slot_i`=1 has no effect. It produces no output, and it neither breaks a run of uncorrectable codewords nor uses up the "first after address" position.
- R10: While `rst_ni` is low, every pulse output and `in_call_o` are 0. After reset, no call is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cw_valid_i | input | 1 | Codeword present this cycle |
| cw_i | input | 32 | Corrected codeword, bit 1 (MSB) on bit 31 |
| cw_uncorr_i | input | 1 | Codeword could not be corrected |
| sync_slot_i | input | 1 | Codeword occupies the batch sync slot |
| frame_i | input | 3 | Frame index of the codeword |
| user_addr_i | input | NUM_ADDR*18 | Upper 18 bits of each user address |
| frame_lo_i | input | 3 | Frame of addresses 0 and 1 |
| frame_hi_i | input | 3 | Frame of addresses 2 and 3 |
| err_pol_i | input | 2 | Uncorrectable-codeword termination policy |
| call_start_o | output | 1 | Call accepted (pulse) |
| call_idx_o | output | 2 | Matching address of accepted call |
| call_func_o | output | 2 | Function bits of accepted call |
| msg_valid_o | output | 1 | Message payload valid (pulse) |
| msg_data_o | output | 20 | Message payload |
| call_end_o | output | 1 | Call terminated, alert request (pulse) |
| end_idx_o | output | 2 | Address of the ended call |
| end_func_o | output | 2 | Function bits of the ended call |
| in_call_o | output | 1 | A call is open |

## Verification
Suppose the open-call flag is wrong. Message payloads then appear or vanish at the next codeword, and `call_end_o` fires with no start before it. A lost uncorrectable-run flag or first-after-address flag shows up only at the next uncorrectable codeword, as a close pulse that comes a codeword too early or too late. Stale identity registers show up only at the next close, as a wrong `end_idx_o` or `end_func_o`, so the sequences check every close pulse against the call that opened it. This matters most for back-to-back calls.

// File: rtl/pgr_pkg.sv
package pgr_pkg;
  localparam int CW_W      = 32;
  localparam int ADDR_HI_W = 18;
  localparam int PAY_W     = 20;
  localparam int FUNC_W    = 2;
  localparam int FRAME_W   = 3;
  localparam int ADDR_LSB  = CW_W - 1 - ADDR_HI_W;   // 13
  localparam int FUNC_LSB  = ADDR_LSB - FUNC_W;       // 11
  localparam int PAY_LSB   = CW_W - 1 - PAY_W;        // 11

  typedef enum logic [1:0] {
    POL_FIRST_A = 2'b00,
    POL_FIRST_B = 2'b01,
    POL_SINGLE  = 2'b10,
    POL_DOUBLE  = 2'b11
  } err_pol_e;
endpackage

// File: rtl/pgr_addr_match.sv
module pgr_addr_match
  import pgr_pkg::*;
#(
  parameter int NUM_ADDR = 4,
  localparam int IDX_W   = $clog2(NUM_ADDR),
  localparam int PER_GRP = NUM_ADDR / 2
) (
  input  logic [ADDR_HI_W-1:0]                addr_field_i,
  input  logic [FRAME_W-1:0]                  frame_i,
  input  logic [NUM_ADDR-1:0][ADDR_HI_W-1:0]  user_addr_i,
  input  logic [FRAME_W-1:0]                  frame_lo_i,
  input  logic [FRAME_W-1:0]                  frame_hi_i,
  output logic                                hit_o,
  output logic [IDX_W-1:0]                    idx_o
);
  logic [NUM_ADDR-1:0] hits;

  for (genvar k = 0; k < NUM_ADDR; k++) begin : g_cmp
    logic [FRAME_W-1:0] own_frame;
    if (k < PER_GRP) begin : g_lo
      assign own_frame = frame_lo_i;
    end else begin : g_hi
      assign own_frame = frame_hi_i;
    end
    assign hits[k] = (addr_field_i == user_addr_i[k]) && (frame_i == own_frame);
  end

  // lowest index has priority
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int k = NUM_ADDR - 1; k >= 0; k--) begin
      if (hits[k]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/pgr_term_policy.sv
module pgr_term_policy
  import pgr_pkg::*;
(
  input  logic       active_i,     // in call, valid, not sync slot
  input  logic       uncorr_i,
  input  logic       is_idle_i,
  input  logic       msb_zero_i,
  input  logic       first_i,      // first codeword after address
  input  logic       prev_unc_i,
  input  logic [1:0] err_pol_i,
  output logic       end_o
);
  err_pol_e pol;
  assign pol = err_pol_e'(err_pol_i);

  always_comb begin
    end_o = 1'b0;
    if (active_i) begin
      if (!uncorr_i) begin
        end_o = is_idle_i || msb_zero_i;
      end else begin
        unique case (pol)
          POL_SINGLE:               end_o = 1'b1;
          POL_DOUBLE:               end_o = prev_unc_i;
          POL_FIRST_A, POL_FIRST_B: end_o = prev_unc_i || first_i;
          default:                  end_o = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/pgr_call_ctrl.sv
module pgr_call_ctrl
  import pgr_pkg::*;
#(
  parameter int          NUM_ADDR = 4,
  parameter logic [31:0] IDLE_CW  = 32'h7A89C197,
  localparam int         IDX_W    = $clog2(NUM_ADDR)
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               cw_valid_i,
  input  logic [CW_W-1:0]                    cw_i,
  input  logic                               cw_uncorr_i,
  input  logic                               sync_slot_i,
  input  logic [FRAME_W-1:0]                 frame_i,
  input  logic [NUM_ADDR-1:0][ADDR_HI_W-1:0] user_addr_i,
  input  logic [FRAME_W-1:0]                 frame_lo_i,
  input  logic [FRAME_W-1:0]                 frame_hi_i,
  input  logic [1:0]                         err_pol_i,
  output logic                               call_start_o,
  output logic [IDX_W-1:0]                   call_idx_o,
  output logic [FUNC_W-1:0]                  call_func_o,
  output logic                               msg_valid_o,
  output logic [PAY_W-1:0]                   msg_data_o,
  output logic                               call_end_o,
  output logic [IDX_W-1:0]                   end_idx_o,
  output logic [FUNC_W-1:0]                  end_func_o,
  output logic                               in_call_o
);
  logic             active, good, is_idle, msb_zero, is_addr;
  logic             hit, new_call, end_call, take_msg;
  logic [IDX_W-1:0] hit_idx;
  logic             in_call_q, first_q, prev_unc_q;
  logic [IDX_W-1:0] cur_idx_q;
  logic [FUNC_W-1:0] cur_func_q;

  assign active   = cw_valid_i && !sync_slot_i;
  assign good     = active && !cw_uncorr_i;
  assign is_idle  = (cw_i == IDLE_CW);
  assign msb_zero = !cw_i[CW_W-1];
  assign is_addr  = msb_zero && !is_idle;

  pgr_addr_match #(.NUM_ADDR(NUM_ADDR)) u_match (
    .addr_field_i (cw_i[CW_W-2:ADDR_LSB]),
    .frame_i      (frame_i),
    .user_addr_i  (user_addr_i),
    .frame_lo_i   (frame_lo_i),
    .frame_hi_i   (frame_hi_i),
    .hit_o        (hit),
    .idx_o        (hit_idx)
  );

  pgr_term_policy u_term (
    .active_i   (active && in_call_q),
    .uncorr_i   (cw_uncorr_i),
    .is_idle_i  (is_idle),
    .msb_zero_i (msb_zero),
    .first_i    (first_q),
    .prev_unc_i (prev_unc_q),
    .err_pol_i  (err_pol_i),
    .end_o      (end_call)
  );

  // terminating address codeword is re-evaluated in the same cycle
  assign new_call = good && is_addr && hit;
  assign take_msg = good && in_call_q && !msb_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_call_q  <= 1'b0;
      first_q    <= 1'b0;
      prev_unc_q <= 1'b0;
      cur_idx_q  <= '0;
      cur_func_q <= '0;
    end else if (active) begin
      in_call_q  <= new_call || (in_call_q && !end_call);
      first_q    <= new_call;
      prev_unc_q <= cw_uncorr_i && !new_call;
      if (new_call) begin
        cur_idx_q  <= hit_idx;
        cur_func_q <= cw_i[FUNC_LSB +: FUNC_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      call_start_o <= 1'b0;
      call_idx_o   <= '0;
      call_func_o  <= '0;
      msg_valid_o  <= 1'b0;
      msg_data_o   <= '0;
      call_end_o   <= 1'b0;
      end_idx_o    <= '0;
      end_func_o   <= '0;
    end else begin
      call_start_o <= new_call;
      msg_valid_o  <= take_msg;
      call_end_o   <= end_call;
      if (new_call) begin
        call_idx_o  <= hit_idx;
        call_func_o <= cw_i[FUNC_LSB +: FUNC_W];
      end
      if (take_msg) msg_data_o <= cw_i[PAY_LSB +: PAY_W];
      if (end_call) begin
        end_idx_o  <= cur_idx_q;
        end_func_o <= cur_func_q;
      end
    end
  end

  assign in_call_o = in_call_q;

  AST_START_FROM_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_start_o |-> $past(cw_valid_i && !cw_uncorr_i && !cw_i[CW_W-1] && !sync_slot_i)); // R1
  AST_MSG_IN_CALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> in_call_o); // R3
  AST_END_NEEDS_CALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_end_o |-> $past(in_call_o)); // R4
  AST_START_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_start_o |-> in_call_o); // R5
  AST_POL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_call_o && cw_valid_i && !sync_slot_i && cw_uncorr_i && err_pol_i == 2'b10)
      |=> call_end_o); // R6
  AST_SYNC_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cw_valid_i && sync_slot_i) |=> (!msg_valid_o && !call_start_o && !call_end_o)); // R9
endmodule

// File: tb/pgr_call_ctrl_test.sv
module pgr_call_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] IDLE = 32'h7A89C197;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cw_valid = 1'b0, cw_unc = 1'b0, sync_slot = 1'b0;
  logic [31:0] cw = '0;
  logic [2:0] frame = '0;
  logic [3:0][17:0] uaddr;
  logic [1:0] pol = 2'b11;
  logic call_start, msg_valid, call_end, in_call;
  logic [1:0] call_idx, call_func, end_idx, end_func;
  logic [19:0] msg_data;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign uaddr[0] = 18'h12345;
  assign uaddr[1] = 18'h00ABC;
  assign uaddr[2] = 18'h3FFFF;
  assign uaddr[3] = 18'h3FFFF;

  pgr_call_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .cw_valid_i(cw_valid), .cw_i(cw),
    .cw_uncorr_i(cw_unc), .sync_slot_i(sync_slot), .frame_i(frame),
    .user_addr_i(uaddr), .frame_lo_i(3'd3), .frame_hi_i(3'd5), .err_pol_i(pol),
    .call_start_o(call_start), .call_idx_o(call_idx), .call_func_o(call_func),
    .msg_valid_o(msg_valid), .msg_data_o(msg_data), .call_end_o(call_end),
    .end_idx_o(end_idx), .end_func_o(end_func), .in_call_o(in_call)
  );

  function automatic logic [31:0] acw(logic [17:0] a, logic [1:0] f);
    return {1'b0, a, f, 11'h155};
  endfunction
  function automatic logic [31:0] mcw(logic [19:0] p);
    return {1'b1, p, 11'h2AA};
  endfunction

  typedef struct packed {
    logic sync; logic unc; logic [2:0] frame; logic [31:0] cw;
    logic st; logic mg; logic en; logic [19:0] data;
    logic [1:0] idx; logic [1:0] func; logic [1:0] eidx; logic [1:0] efunc;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,3'd3,acw(18'h12345,2'd2), 1'b1,1'b0,1'b0,20'h0,    2'd0,2'd2,2'd0,2'd0}, // R1
    '{1'b0,1'b0,3'd6,mcw(20'hABCDE),      1'b0,1'b1,1'b0,20'hABCDE,2'd0,2'd0,2'd0,2'd0}, // R3
    '{1'b1,1'b1,3'd0,32'hFFFF0000,        1'b0,1'b0,1'b0,20'h0,    2'd0,2'd0,2'd0,2'd0}, // R9
    '{1'b0,1'b0,3'd1,mcw(20'h01234),      1'b0,1'b1,1'b0,20'h01234,2'd0,2'd0,2'd0,2'd0}, // R3
    '{1'b0,1'b0,3'd2,IDLE,                1'b0,1'b0,1'b1,20'h0,    2'd0,2'd0,2'd0,2'd2}, // R4
    '{1'b0,1'b0,3'd3,mcw(20'h11111),      1'b0,1'b0,1'b0,20'h0,    2'd0,2'd0,2'd0,2'd0}, // R3 outside
    '{1'b0,1'b0,3'd4,acw(18'h12345,2'd1), 1'b0,1'b0,1'b0,20'h0,    2'd0,2'd0,2'd0,2'd0}, // R2 frame
    '{1'b0,1'b1,3'd3,acw(18'h12345,2'd1), 1'b0,1'b0,1'b0,20'h0,    2'd0,2'd0,2'd0,2'd0}, // R2 uncorr
    '{1'b0,1'b0,3'd5,acw(18'h3FFFF,2'd1), 1'b1,1'b0,1'b0,20'h0,    2'd2,2'd1,2'd0,2'd0}, // R1 priority
    '{1'b0,1'b1,3'd0,mcw(20'h99999),      1'b0,1'b0,1'b0,20'h0,    2'd0,2'd0,2'd0,2'd0}, // R7 lone
    '{1'b0,1'b0,3'd0,mcw(20'h22222),      1'b0,1'b1,1'b0,20'h22222,2'd0,2'd0,2'd0,2'd0}, // R7
    '{1'b0,1'b1,3'd0,mcw(20'h33333),      1'b0,1'b0,1'b0,20'h0,    2'd0,2'd0,2'd0,2'd0}, // R7
    '{1'b1,1'b0,3'd0,32'h7CD215D8,        1'b0,1'b0,1'b0,20'h0,    2'd0,2'd0,2'd0,2'd0}, // R9
    '{1'b0,1'b1,3'd0,mcw(20'h44444),      1'b0,1'b0,1'b1,20'h0,    2'd0,2'd0,2'd2,2'd1}, // R7 R9
    '{1'b0,1'b0,3'd3,acw(18'h00ABC,2'd3), 1'b1,1'b0,1'b0,20'h0,    2'd1,2'd3,2'd0,2'd0}, // R1
    '{1'b0,1'b1,3'd0,mcw(20'h55555),      1'b0,1'b0,1'b0,20'h0,    2'd0,2'd0,2'd0,2'd0}, // R7 first
    '{1'b0,1'b0,3'd0,acw(18'h00001,2'd0), 1'b0,1'b0,1'b1,20'h0,    2'd0,2'd0,2'd1,2'd3}, // R5 no match
    '{1'b0,1'b0,3'd3,acw(18'h12345,2'd0), 1'b1,1'b0,1'b0,20'h0,    2'd0,2'd0,2'd0,2'd0}, // R1
    '{1'b0,1'b0,3'd5,acw(18'h3FFFF,2'd3), 1'b1,1'b0,1'b1,20'h0,    2'd2,2'd3,2'd0,2'd0}, // R5 restart
    '{1'b0,1'b0,3'd7,IDLE,                1'b0,1'b0,1'b1,20'h0,    2'd0,2'd0,2'd2,2'd3}  // R4
  };

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic send(logic s, logic u, logic [2:0] f, logic [31:0] c);
    @(negedge clk);
    cw_valid = 1'b1; sync_slot = s; cw_unc = u; frame = f; cw = c;
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    @(negedge clk);
    cw_valid = 1'b0; sync_slot = 1'b0; cw_unc = 1'b0;
  endtask

  task automatic chk_pulses(string req, logic st, logic mg, logic en);
    chk({req, " start"}, {31'd0, call_start}, {31'd0, st});
    chk({req, " msg"},   {31'd0, msg_valid},  {31'd0, mg});
    chk({req, " end"},   {31'd0, call_end},   {31'd0, en});
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R10 reset state
    #(CLK_PERIOD * 2);
    chk_pulses("R10 reset", 1'b0, 1'b0, 1'b0);
    chk("R10 in_call", {31'd0, in_call}, 32'd0);
    @(negedge clk); rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      send(VEC[i].sync, VEC[i].unc, VEC[i].frame, VEC[i].cw);
      chk_pulses($sformatf("R1-vec%0d", i), VEC[i].st, VEC[i].mg, VEC[i].en);
      if (VEC[i].st) begin
        chk("R1 idx",  {30'd0, call_idx},  {30'd0, VEC[i].idx});
        chk("R1 func", {30'd0, call_func}, {30'd0, VEC[i].func});
      end
      if (VEC[i].mg) chk("R3 data", {12'd0, msg_data}, {12'd0, VEC[i].data});
      if (VEC[i].en) begin
        chk("R4 end idx",  {30'd0, end_idx},  {30'd0, VEC[i].eidx});
        chk("R4 end func", {30'd0, end_func}, {30'd0, VEC[i].efunc});
      end
    end
    quiet();
    chk("R4 closed", {31'd0, in_call}, 32'd0);

    // R6 single uncorrectable ends
    pol = 2'b10;
    send(1'b0, 1'b0, 3'd3, acw(18'h12345, 2'd1));
    send(1'b0, 1'b0, 3'd0, mcw(20'h0F0F0));
    chk_pulses("R6 msg", 1'b0, 1'b1, 1'b0);
    send(1'b0, 1'b1, 3'd0, mcw(20'h0));
    chk_pulses("R6", 1'b0, 1'b0, 1'b1);
    chk("R6 end func", {30'd0, end_func}, 32'd1);
    quiet();

    // R8 first after address uncorrectable
    pol = 2'b00;
    send(1'b0, 1'b0, 3'd3, acw(18'h12345, 2'd0));
    send(1'b0, 1'b1, 3'd0, mcw(20'h0));
    chk_pulses("R8 first", 1'b0, 1'b0, 1'b1);
    quiet();

    // R8 mid-call single does not end, consecutive does
    pol = 2'b01;
    send(1'b0, 1'b0, 3'd5, acw(18'h3FFFF, 2'd2));
    send(1'b0, 1'b0, 3'd0, mcw(20'h77777));
    send(1'b0, 1'b1, 3'd0, mcw(20'h0));
    chk_pulses("R8 single", 1'b0, 1'b0, 1'b0);
    chk("R8 still open", {31'd0, in_call}, 32'd1);
    send(1'b0, 1'b1, 3'd0, mcw(20'h0));
    chk_pulses("R8 double", 1'b0, 1'b0, 1'b1);
    chk("R8 end idx", {30'd0, end_idx}, 32'd2);
    quiet();

    // R9 sync slot does not use up first position
    pol = 2'b00;
    send(1'b0, 1'b0, 3'd3, acw(18'h00ABC, 2'd0));
    send(1'b1, 1'b0, 3'd0, 32'h7CD215D8);
    chk_pulses("R9 sync", 1'b0, 1'b0, 1'b0);
    send(1'b0, 1'b1, 3'd0, mcw(20'h0));
    chk_pulses("R9 first kept", 1'b0, 1'b0, 1'b1);
    quiet();

    // R10 reset mid-call
    send(1'b0, 1'b0, 3'd3, acw(18'h12345, 2'd0));
    quiet();
    rst_ni = 1'b0;
    #1;
    chk("R10 async clear", {31'd0, in_call}, 32'd0);
    chk_pulses("R10 mid", 1'b0, 1'b0, 1'b0);
    @(negedge clk); rst_ni = 1'b1;
    send(1'b0, 1'b0, 3'd0, mcw(20'h12121));
    chk_pulses("R10 after", 1'b0, 1'b0, 1'b0);
    quiet();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule